// File: doc/BRIEF.md
# Strobe-Clocked One-Time-Programmable Byte Memory

This block models a 512-word by 8-bit memory whose cells start at zero and can only be set, one bit at a time. It reads in step with a chip-enable strobe that is sampled on the system clock. When the strobe goes low, the block captures the address into an internal register. When the strobe goes high again, the addressed byte is loaded into an output register. The output register then holds that byte while the next address is captured, so the memory can sit in a pipelined data path or stand in for synchronous logic.

Storage is a grid of 64 rows, each 64 bits wide. The upper six address bits choose a row, and the lower three choose an 8-bit column group within it. Three output-enable inputs gate the data bus, and each enable has a polarity parameter. The bus is modelled as a data vector plus a drive flag. The enables act at once and do not depend on the strobe.

A program request names a bit index within the word whose address is currently latched. The request takes effect only while the strobe is in its low phase, and it can only change a 0 into a 1.

Top module: `prom_strobe_rom`

## Requirements
- R1: The memory holds 512 words of 8 bits and takes a 9-bit address `addr`. A completed read cycle returns the byte most recently built up at that address. A read cycle is the strobe held low for at least one clock edge, then high for one edge.
- R2: The address is captured at the clock edge where `stb` is sampled 0 and was sampled 1 at the previous edge. Changes on `addr` later in the same low phase have no effect on which word is read.
- R3: The output register loads only at the clock edge where `stb` is sampled 1 and was sampled 0 at the previous edge. It holds its value through the following low phase, when the next address is captured.
- R4: After reset, every cell reads as 0 and the output register holds 0.
- R5: A program operation is accepted at a clock edge when `prog_req` is 1 and `stb` was sampled 0 at both that edge and the previous one. It sets bit `prog_bit` (0 = least significant bit) of the latched word to 1 and changes no other cell.
- R6: No cell ever changes from 1 to 0, and no clock edge changes more than one cell.
- R7: A program request made while the strobe is high, or at the edge where the address is captured, leaves the array unchanged.
- R8: A program request aimed at a bit that is already 1 leaves the array unchanged.
- R9: With the default polarities, `q_drv` is 1 exactly when `oe_a`=1, `oe_b`=0 and `oe_c`=0. While `q_drv` is 1, `q` equals the output register. While `q_drv` is 0, `q` is all zeros.
- R10: `q_drv` and `q` follow the enable inputs combinationally, with no dependence on the strobe phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobe |
| rst_n | input | 1 | Active-low asynchronous reset; clears the cells and the output register |
| stb | input | 1 | Chip-enable strobe; idles high |
| addr | input | 9 | Word address, captured as the strobe goes low |
| prog_req | input | 1 | Request to set one bit of the latched word |
| prog_bit | input | 3 | Index of the bit to set |
| oe_a | input | 1 | Output enable A (active high by default) |
| oe_b | input | 1 | Output enable B (active low by default) |
| oe_c | input | 1 | Output enable C (active low by default) |
| q | output | 8 | Data bus value; zero when not driven |
| q_drv | output | 1 | Data bus drive enable |

## Verification
The hardest case to reach from the ports is a program request that lands just outside the accepted window. That means a request during the strobe's high phase, or at the very edge that captures the address. Either one could wrongly set a bit in the word that is latched. The stimulus first programs every word with an address-derived pattern. It then latches words that still have zero bits and fires requests at those bits, in both rejected timings and on bits already set. Each affected word is read back and compared against the bench's shadow copy. The reads also check two more things: that the output register holds its value while the next address is captured, and that address changes in mid-phase are ignored.

// File: rtl/prom_pkg.sv
package prom_pkg;

   // strobe phase events derived from two successive samples
   typedef struct packed {
      logic fall;   // sampled low now, high at the previous edge
      logic rise;   // sampled high now, low at the previous edge
      logic low;    // sampled low now and at the previous edge
   } strobe_ev_t;

endpackage

// File: rtl/prom_strobe_sync.sv
module prom_strobe_sync
   import prom_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stb,
   output logic       stb_q,
   output strobe_ev_t ev
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q <= 1'b1;
      else        stb_q <= stb;
   end

   always_comb begin
      ev.fall = stb_q & ~stb;
      ev.rise = ~stb_q & stb;
      ev.low  = ~stb_q & ~stb;
   end

endmodule

// File: rtl/prom_addr_latch.sv
module prom_addr_latch
   import prom_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int ROW_W  = 6,
   localparam int COL_W = ADDR_W - ROW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  strobe_ev_t        ev,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] lat_addr,
   output logic [ROW_W-1:0]  row_sel,
   output logic [COL_W-1:0]  grp_sel
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lat_addr <= '0;
      else if (ev.fall) lat_addr <= addr;
   end

   assign row_sel = lat_addr[ADDR_W-1:COL_W];
   assign grp_sel = lat_addr[COL_W-1:0];

endmodule

// File: rtl/prom_cell_array.sv
module prom_cell_array #(
   parameter int ROW_W  = 6,
   parameter int COL_W  = 3,
   parameter int DATA_W = 8,
   localparam int ROWS     = 2 ** ROW_W,
   localparam int GROUPS   = 2 ** COL_W,
   localparam int ROW_BITS = GROUPS * DATA_W,
   localparam int BIT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ROW_W-1:0]         row_sel,
   input  logic [COL_W-1:0]         grp_sel,
   input  logic                     wr_gate,
   input  logic                     prog_req,
   input  logic [BIT_W-1:0]         prog_bit,
   output logic [DATA_W-1:0]        rd_word,
   output logic [ROWS*ROW_BITS-1:0] cells_flat
);

   logic [ROW_BITS-1:0] cells [ROWS];
   logic                wr_en;
   logic [ROW_BITS-1:0] set_mask;

   assign wr_en = wr_gate & prog_req & (int'(prog_bit) < DATA_W);

   // one-hot column mask: group picks the byte lane, bit index the column in it
   always_comb begin
      set_mask = '0;
      set_mask[int'(grp_sel) * DATA_W + int'(prog_bit)] = 1'b1;
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cells[r] <= '0;
         else if (wr_en && (int'(row_sel) == r))
            cells[r] <= cells[r] | set_mask;
      end
      assign cells_flat[r*ROW_BITS +: ROW_BITS] = cells[r];
   end

   assign rd_word = cells[row_sel][int'(grp_sel)*DATA_W +: DATA_W];

endmodule

// File: rtl/prom_out_stage.sv
module prom_out_stage #(
   parameter int         DATA_W      = 8,
   parameter logic [2:0] OE_ACT_HIGH = 3'b001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] rd_word,
   input  logic [2:0]        oe_raw,
   output logic [DATA_W-1:0] out_reg,
   output logic [DATA_W-1:0] q,
   output logic              q_drv
);

   logic [2:0] oe_on;

   for (genvar i = 0; i < 3; i++) begin : g_oe
      if (OE_ACT_HIGH[i]) begin : g_hi
         assign oe_on[i] = oe_raw[i];
      end else begin : g_lo
         assign oe_on[i] = ~oe_raw[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    out_reg <= '0;
      else if (load) out_reg <= rd_word;
   end

   assign q_drv = &oe_on;
   assign q     = q_drv ? out_reg : '0;

endmodule

// File: rtl/prom_strobe_rom.sv
module prom_strobe_rom
   import prom_pkg::*;
#(
   parameter int         ADDR_W      = 9,
   parameter int         DATA_W      = 8,
   parameter int         ROW_W       = 6,
   parameter logic [2:0] OE_ACT_HIGH = 3'b001,
   localparam int COL_W    = ADDR_W - ROW_W,
   localparam int ROWS     = 2 ** ROW_W,
   localparam int ROW_BITS = (2 ** COL_W) * DATA_W,
   localparam int BIT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic              prog_req,
   input  logic [BIT_W-1:0]  prog_bit,
   input  logic              oe_a,
   input  logic              oe_b,
   input  logic              oe_c,
   output logic [DATA_W-1:0] q,
   output logic              q_drv
);

   if (ROW_W < 1 || ROW_W >= ADDR_W) begin : g_bad_row
      $error("ROW_W must lie between 1 and ADDR_W-1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end
   if (ROWS * ROW_BITS > 65536) begin : g_bad_size
      $error("array too large for this model");
   end

   strobe_ev_t               ev;
   logic                     stb_q;
   logic [ADDR_W-1:0]        lat_addr;
   logic [ROW_W-1:0]         row_sel;
   logic [COL_W-1:0]         grp_sel;
   logic [DATA_W-1:0]        rd_word;
   logic [DATA_W-1:0]        out_reg;
   logic [ROWS*ROW_BITS-1:0] cells_flat;

   prom_strobe_sync i_sync (
      .clk(clk), .rst_n(rst_n), .stb(stb), .stb_q(stb_q), .ev(ev)
   );

   prom_addr_latch #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) i_alat (
      .clk(clk), .rst_n(rst_n), .ev(ev), .addr(addr),
      .lat_addr(lat_addr), .row_sel(row_sel), .grp_sel(grp_sel)
   );

   prom_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) i_cells (
      .clk(clk), .rst_n(rst_n), .row_sel(row_sel), .grp_sel(grp_sel),
      .wr_gate(ev.low), .prog_req(prog_req), .prog_bit(prog_bit),
      .rd_word(rd_word), .cells_flat(cells_flat)
   );

   prom_out_stage #(.DATA_W(DATA_W), .OE_ACT_HIGH(OE_ACT_HIGH)) i_out (
      .clk(clk), .rst_n(rst_n), .load(ev.rise), .rd_word(rd_word),
      .oe_raw({oe_c, oe_b, oe_a}), .out_reg(out_reg), .q(q), .q_drv(q_drv)
   );

endmodule

// File: rtl/prom_strobe_rom_chk.sv
module prom_strobe_rom_chk #(
   parameter int         ADDR_W      = 9,
   parameter int         DATA_W      = 8,
   parameter int         NBITS       = 4096,
   parameter logic [2:0] OE_ACT_HIGH = 3'b001
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stb,
   input logic              stb_q,
   input logic [ADDR_W-1:0] addr,
   input logic              oe_a,
   input logic              oe_b,
   input logic              oe_c,
   input logic [DATA_W-1:0] q,
   input logic              q_drv,
   input logic [ADDR_W-1:0] lat_addr,
   input logic [DATA_W-1:0] out_reg,
   input logic [NBITS-1:0]  cells_flat
);

   // R2
   addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb && stb_q) |=> (lat_addr == $past(addr)));

   // R2
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!stb && stb_q) |=> $stable(lat_addr));

   // R3
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(stb && !stb_q) |=> $stable(out_reg));

   // R6
   no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(cells_flat) & ~cells_flat) == '0));

   // R6
   one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(cells_flat ^ $past(cells_flat)) <= 1));

   // R7
   high_prog_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_q || stb) |=> $stable(cells_flat));

   // R9
   drive_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_drv == ((oe_a == OE_ACT_HIGH[0]) && (oe_b == OE_ACT_HIGH[1])
                && (oe_c == OE_ACT_HIGH[2])));

   // R9
   bus_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q == (q_drv ? out_reg : '0));

endmodule

bind prom_strobe_rom prom_strobe_rom_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBITS(ROWS*ROW_BITS),
   .OE_ACT_HIGH(OE_ACT_HIGH)
) i_chk (
   .clk(clk), .rst_n(rst_n), .stb(stb), .stb_q(stb_q), .addr(addr),
   .oe_a(oe_a), .oe_b(oe_b), .oe_c(oe_c), .q(q), .q_drv(q_drv),
   .lat_addr(lat_addr), .out_reg(out_reg), .cells_flat(cells_flat)
);

// File: tb/test_prom_strobe_rom.sv
module test_prom_strobe_rom;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stb = 1'b1;
   logic [8:0] addr = '0;
   logic       prog_req = 1'b0;
   logic [2:0] prog_bit = '0;
   logic       oe_a = 1'b1, oe_b = 1'b0, oe_c = 1'b0;
   logic [7:0] q;
   logic       q_drv;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   logic [7:0] shadow [512];

   always #10 clk = ~clk;   // 50 MHz

   prom_strobe_rom i_prom_strobe_rom (
      .clk(clk), .rst_n(rst_n), .stb(stb), .addr(addr),
      .prog_req(prog_req), .prog_bit(prog_bit),
      .oe_a(oe_a), .oe_b(oe_b), .oe_c(oe_c), .q(q), .q_drv(q_drv)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         total++; bad++;
         $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [7:0] pat(int a);
      return 8'((a * 29) ^ (a >> 2) ^ 8'h5A);
   endfunction

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic latch(int a);
      addr = 9'(a);
      stb  = 1'b0;
      cyc();
   endtask

   task automatic prog(int b);
      prog_req = 1'b1;
      prog_bit = 3'(b);
      cyc();
      prog_req = 1'b0;
   endtask

   task automatic finish_read();
      stb = 1'b1;
      cyc();
   endtask

   initial begin
      for (int i = 0; i < 512; i++) shadow[i] = '0;
      repeat (3) @(negedge clk);
      // R4: reset state of the output register on the bus
      chk8("R4 out reg at reset", q, 8'h00);
      rst_n = 1'b1;
      cyc();

      // R4: every word reads zero after reset
      for (int a = 0; a < 512; a++) begin
         latch(a); finish_read();
         chk8("R4 blank word", q, 8'h00);
      end

      // R5: program the pattern one bit at a time
      for (int a = 0; a < 512; a++) begin
         latch(a);
         for (int b = 0; b < 8; b++)
            if (pat(a)[b]) begin
               prog(b);
               shadow[a][b] = 1'b1;
            end
         finish_read();
         chk8("R5 word after programming", q, shadow[a]);
      end

      // R1, R3: full sweep read-back; output holds during the next capture
      for (int a = 0; a < 512; a++) begin
         latch(a);
         chk8("R3 hold during capture", q, shadow[(a + 511) % 512]);
         finish_read();
         chk8("R1 read-back", q, shadow[a]);
      end

      // R2: address changes after capture are ignored
      for (int a = 10; a < 20; a++) begin
         latch(a);
         addr = 9'(a + 100);
         cyc();
         finish_read();
         chk8("R2 mid-phase address change", q, shadow[a]);
      end

      // R8: requests on bits already set leave the word unchanged
      for (int a = 30; a < 40; a++) begin
         latch(a);
         for (int b = 0; b < 8; b++)
            if (shadow[a][b]) prog(b);
         finish_read();
         chk8("R8 reprogram set bits", q, shadow[a]);
      end

      // R7: requests during high phase and at the capture edge are ignored
      for (int a = 50; a < 70; a++) begin
         latch(a); finish_read();
         for (int b = 0; b < 8; b++)
            if (!shadow[a][b]) prog(b);        // strobe high
         addr = 9'(a);
         stb = 1'b0;
         prog_req = 1'b1;                      // same edge as capture
         for (int b = 0; b < 8; b++)
            if (!shadow[a][b]) prog_bit = 3'(b);
         cyc();
         prog_req = 1'b0;
         finish_read();
         chk8("R7 ignored requests", q, shadow[a]);
      end

      // R5, R6: a single new bit in a word with zero bits
      for (int a = 100; a < 110; a++) begin
         int nb;
         nb = -1;
         for (int b = 0; b < 8; b++) if (!shadow[a][b] && nb < 0) nb = b;
         latch(a);
         if (nb >= 0) begin
            prog(nb);
            shadow[a][nb] = 1'b1;
         end
         finish_read();
         chk8("R6 single bit added", q, shadow[a]);
         latch(a + 1); finish_read();
         chk8("R6 neighbour untouched", q, shadow[a + 1]);
      end

      // R9: enable sweep; out reg currently holds shadow[110]
      for (int m = 0; m < 8; m++) begin
         logic on;
         oe_a = m[0]; oe_b = m[1]; oe_c = m[2];
         #1;
         on = (m == 1);
         chk8("R9 drive flag", {7'b0, q_drv}, {7'b0, on});
         chk8("R9 bus value", q, on ? shadow[110] : 8'h00);
      end

      // R10: enables act during the strobe low phase too
      oe_a = 1'b1; oe_b = 1'b0; oe_c = 1'b0;
      latch(200);
      oe_b = 1'b1; #1;
      chk8("R10 disable in low phase", {7'b0, q_drv}, 8'h00);
      chk8("R10 bus zero in low phase", q, 8'h00);
      oe_b = 1'b0; #1;
      chk8("R10 enable in low phase", q, shadow[110]);
      @(negedge clk);
      finish_read();
      chk8("R10 read after toggling", q, shadow[200]);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule